// File: doc/BRIEF.md
# Variable-to-Factor Gaussian Message Combiner

This block forms one outgoing Gaussian message on the way from a variable node to a factor node in an iterative belief-propagation solver. Upstream logic streams a burst of incoming messages, one per 64-bit beat. Each beat holds a mean and a precision. The final beat of the burst is marked with TLAST. The upstream data order already decides which messages are left out, so the block combines everything it receives.

For each burst, the block adds up the precisions. It also adds up each mean weighted by its own precision. When the closing beat arrives, it divides the weighted sum by the precision sum, which gives the precision-weighted Gaussian product. It returns this result as a single 64-bit beat. All arithmetic is signed Q16.16 fixed point. The input accepts one beat per cycle while a burst is open. After the closing beat it stops accepting input until the result beat has been taken.

Top module: `gmsg_fuse`

## Requirements
- R1: Each input beat carries the mean in bits 63:32 and the precision in bits 31:0. Both are signed Q16.16, so 1.0 is 0x00010000. The result beat uses the same field positions.
- R2: The precision field of the result is the sum of all precisions in the burst, truncated to 32 bits.
- R3: Each mean-precision product is shifted right arithmetically by 16 bits and then accumulated. The mean field of the result is (weighted sum × 2^16) divided by the precision sum. The quotient is truncated toward zero and keeps its low 32 bits.
- R4: Both running sums return to zero after the closing beat of a burst. Each burst's result therefore depends only on its own beats, including after a burst whose precision sum was zero.
- R5: s_tready stays high from reset until a beat with s_tlast is accepted, so the beats of an open burst are taken one per cycle. It is low from the cycle after that beat until the result beat is accepted, and it never overlaps m_tvalid.
- R6: Each burst produces exactly one result beat with m_tlast high. While m_tready is low, m_tvalid and m_tdata hold steady.
- R7: If the precision sum of a burst is zero, the mean field is 0 and err_zero rises. err_zero then stays high until reset.
- R8: After reset, m_tvalid is low, s_tready is high and err_zero is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_tdata | input | 64 | Incoming message: mean in the upper half, precision in the lower half |
| s_tvalid | input | 1 | Incoming beat valid |
| s_tlast | input | 1 | Marks the closing beat of a burst |
| s_tready | output | 1 | Block can take a beat |
| m_tdata | output | 64 | Result message, same layout as the input |
| m_tvalid | output | 1 | Result beat valid |
| m_tlast | output | 1 | High on the result beat |
| m_tready | input | 1 | Downstream takes the result |
| err_zero | output | 1 | Sticky flag: some burst had a zero precision sum |

## Verification
The combiner is driven with several burst patterns:
- A multi-beat burst with positive means tests the core weighted average.
- A burst with negative, non-integer weighted terms tests the product rescaling and truncation toward zero.
- A single-beat burst and a burst with idle cycles between beats test that beat count and spacing do not matter.
- A burst whose precisions cancel to zero tests the zero-divisor path and the sticky flag.
- A result held under backpressure, followed by back-to-back identical bursts, separates a stable output register from leftover accumulator state.

// File: rtl/gmsg_fuse.sv
module gmsg_fuse #(
  parameter int DW    = 32,
  parameter int FRAC  = 16,
  parameter int ACC_W = 48
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2*DW-1:0] s_tdata,
  input  logic          s_tvalid,
  input  logic          s_tlast,
  output logic          s_tready,
  output logic [2*DW-1:0] m_tdata,
  output logic          m_tvalid,
  output logic          m_tlast,
  input  logic          m_tready,
  output logic          err_zero
);
  localparam int QW = ACC_W + FRAC;
  localparam int CW = $clog2(QW + 1);

  logic in_busy;
  logic take;
  assign s_tready = !in_busy;
  assign take     = s_tvalid && s_tready;
  assign m_tlast  = m_tvalid;

  logic                 p_v, p_last;
  logic signed [DW-1:0] p_mean, p_prec;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      p_v <= 1'b0; p_last <= 1'b0; p_mean <= '0; p_prec <= '0;
    end else begin
      p_v <= take;
      if (take) begin
        p_last <= s_tlast;
        p_mean <= s_tdata[2*DW-1:DW];
        p_prec <= s_tdata[DW-1:0];
      end
    end
  end

  logic signed [2*DW-1:0]  prod, prod_sh;
  logic signed [ACC_W-1:0] prod_q, prec_x, acc_p, acc_w, sum_p, sum_w;
  assign prod    = p_mean * p_prec;
  assign prod_sh = prod >>> FRAC;
  assign prod_q  = prod_sh[ACC_W-1:0];
  assign prec_x  = {{(ACC_W-DW){p_prec[DW-1]}}, p_prec};
  assign sum_p   = acc_p + prec_x;
  assign sum_w   = acc_w + prod_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_p <= '0; acc_w <= '0;
    end else if (p_v) begin
      acc_p <= p_last ? '0 : sum_p;
      acc_w <= p_last ? '0 : sum_w;
    end
  end

  logic [ACC_W-1:0] mag_w, mag_p;
  assign mag_w = sum_w[ACC_W-1] ? ACC_W'(-sum_w) : ACC_W'(sum_w);
  assign mag_p = sum_p[ACC_W-1] ? ACC_W'(-sum_p) : ACC_W'(sum_p);

  logic          div_busy, neg;
  logic [CW-1:0] cnt;
  logic [QW-1:0] dvd, quo;
  logic [ACC_W-1:0] rem, den;
  logic [DW-1:0] res_prec;

  logic [ACC_W:0]   trial;
  logic             ge;
  logic [QW-1:0]    q_fin, q_sgn;
  assign trial = {rem, dvd[QW-1]};
  assign ge    = trial >= {1'b0, den};
  assign q_fin = {quo[QW-2:0], ge};
  assign q_sgn = neg ? (~q_fin + 1'b1) : q_fin;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_busy <= 1'b0; div_busy <= 1'b0; neg <= 1'b0; cnt <= '0;
      dvd <= '0; quo <= '0; rem <= '0; den <= '0; res_prec <= '0;
      m_tvalid <= 1'b0; m_tdata <= '0; err_zero <= 1'b0;
    end else begin
      if (take && s_tlast) in_busy <= 1'b1;
      if (m_tvalid && m_tready) begin
        m_tvalid <= 1'b0;
        in_busy  <= 1'b0;
      end
      if (p_v && p_last) begin
        res_prec <= sum_p[DW-1:0];
        if (sum_p == '0) begin
          m_tvalid <= 1'b1;
          m_tdata  <= {{DW{1'b0}}, sum_p[DW-1:0]};
          err_zero <= 1'b1;
        end else begin
          div_busy <= 1'b1;
          cnt      <= CW'(QW);
          dvd      <= {mag_w, {FRAC{1'b0}}};
          den      <= mag_p;
          rem      <= '0;
          quo      <= '0;
          neg      <= sum_w[ACC_W-1] ^ sum_p[ACC_W-1];
        end
      end
      if (div_busy) begin
        rem <= ge ? ACC_W'(trial - {1'b0, den}) : trial[ACC_W-1:0];
        dvd <= dvd << 1;
        quo <= q_fin;
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) begin
          div_busy <= 1'b0;
          m_tvalid <= 1'b1;
          m_tdata  <= {q_sgn[DW-1:0], res_prec};
        end
      end
    end
  end
endmodule

// File: rtl/gmsg_fuse_chk.sv
module gmsg_fuse_chk #(
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_tvalid,
  input logic          s_tlast,
  input logic          s_tready,
  input logic [2*DW-1:0] m_tdata,
  input logic          m_tvalid,
  input logic          m_tready,
  input logic          err_zero
);
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && !m_tready |=> m_tvalid && $stable(m_tdata));

  p_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    s_tvalid && s_tready && s_tlast |=> !s_tready);

  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid |-> !s_tready);

  p_reopen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    m_tvalid && m_tready |=> s_tready);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_zero |=> err_zero);
endmodule

bind gmsg_fuse gmsg_fuse_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_tvalid(s_tvalid), .s_tlast(s_tlast),
  .s_tready(s_tready), .m_tdata(m_tdata), .m_tvalid(m_tvalid),
  .m_tready(m_tready), .err_zero(err_zero)
);

// File: tb/gmsg_fuse_tb.sv
`timescale 1ns/1ps
module gmsg_fuse_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] s_tdata = '0;
  logic s_tvalid = 1'b0, s_tlast = 1'b0, s_tready;
  logic [63:0] m_tdata;
  logic m_tvalid, m_tlast, err_zero;
  logic m_tready = 1'b1;

  always #2 clk = ~clk;

  gmsg_fuse u_dut (
    .clk(clk), .rst_n(rst_n), .s_tdata(s_tdata), .s_tvalid(s_tvalid),
    .s_tlast(s_tlast), .s_tready(s_tready), .m_tdata(m_tdata),
    .m_tvalid(m_tvalid), .m_tlast(m_tlast), .m_tready(m_tready),
    .err_zero(err_zero)
  );

  int n_run = 0, n_fail = 0;
  bit done = 0;
  logic [63:0] eq[$];
  bit ez[$];
  int bm[16], bp[16];

  task automatic chk(bit ok, string req, longint act, longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic predict(int n);
    longint ps = 0, ws = 0, a, q;
    logic [63:0] e;
    for (int i = 0; i < n; i++) begin
      ps += longint'(bp[i]);
      ws += (longint'(bm[i]) * longint'(bp[i])) >>> 16;
    end
    if (ps == 0) q = 0;
    else begin
      a = (ws < 0 ? -ws : ws) << 16;
      q = a / (ps < 0 ? -ps : ps);
      if ((ws < 0) != (ps < 0)) q = -q;
    end
    e = {q[31:0], ps[31:0]};
    eq.push_back(e);
    ez.push_back(ps == 0);
  endtask

  task automatic burst(int n, int gap);
    int stall;
    predict(n);
    for (int i = 0; i < n; i++) begin
      s_tvalid = 1'b1;
      s_tdata  = {bm[i][31:0], bp[i][31:0]};
      s_tlast  = (i == n - 1);
      stall = 0;
      @(negedge clk);
      while (!s_tready) begin stall++; @(negedge clk); end
      if (i > 0) chk(stall == 0, "R5 beat stalled inside burst", stall, 0);
      @(posedge clk); #1;
      s_tvalid = 1'b0;
      s_tlast  = 1'b0;
      if (i < n - 1) repeat (gap) begin @(posedge clk); #1; end
    end
    @(negedge clk);
    chk(s_tready == 1'b0, "R5 ready after closing beat", s_tready, 0);
    @(posedge clk); #1;
  endtask

  task automatic drain();
    while (eq.size() > 0) @(negedge clk);
    @(posedge clk); #1;
  endtask

  logic [63:0] hd;
  bit held = 0;
  always @(negedge clk) begin
    if (rst_n && m_tvalid) begin
      if (held) chk(m_tdata == hd, "R6 data moved under backpressure", m_tdata, hd);
      if (m_tready) begin
        held = 0;
        if (eq.size() == 0) chk(0, "R6 unexpected result beat", m_tdata, 0);
        else begin
          logic [63:0] e;
          bit z;
          e = eq.pop_front();
          z = ez.pop_front();
          chk(m_tdata[63:32] == e[63:32], "R3 mean field", m_tdata[63:32], e[63:32]);
          chk(m_tdata[31:0] == e[31:0], "R2 precision field", m_tdata[31:0], e[31:0]);
          chk(m_tlast == 1'b1, "R6 last flag on result", m_tlast, 1);
          if (z) chk(err_zero == 1'b1, "R7 zero-sum flag", err_zero, 1);
        end
      end else begin
        held = 1;
        hd = m_tdata;
      end
    end
  end

  initial begin
    #400000;
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(m_tvalid == 1'b0, "R8 valid after reset", m_tvalid, 0);
    chk(s_tready == 1'b1, "R8 ready after reset", s_tready, 1);
    chk(err_zero == 1'b0, "R8 flag after reset", err_zero, 0);
    @(posedge clk); #1;

    // R1 R2 R3: weighted average over three beats
    bm[0] = 32'sh0002_0000; bp[0] = 32'sh0001_0000;
    bm[1] = 32'sh0004_0000; bp[1] = 32'sh0003_0000;
    bm[2] = -32'sh0001_0000; bp[2] = 32'sh0000_8000;
    burst(3, 0);
    drain();

    // R3: single beat, negative mean
    bm[0] = -32'sh0003_4000; bp[0] = 32'sh0002_0000;
    burst(1, 0);
    drain();

    // R3: non-integer negative result with idle gaps, truncation toward zero
    bm[0] = 32'sh0001_8000; bp[0] = 32'sh0000_4000;
    bm[1] = -32'sh0005_2000; bp[1] = 32'sh0001_3000;
    bm[2] = 32'sh0000_0555; bp[2] = 32'sh0000_7000;
    bm[3] = -32'sh0002_0001; bp[3] = 32'sh0002_0000;
    burst(4, 3);
    drain();

    // R7: precisions cancel
    bm[0] = 32'sh0005_0000; bp[0] = 32'sh0001_0000;
    bm[1] = 32'sh0007_0000; bp[1] = -32'sh0001_0000;
    burst(2, 0);
    drain();

    // R4: fresh result after the zero-sum burst
    bm[0] = 32'sh0003_0000; bp[0] = 32'sh0002_0000;
    bm[1] = 32'sh0006_0000; bp[1] = 32'sh0001_0000;
    burst(2, 1);
    drain();
    chk(err_zero == 1'b1, "R7 flag stays set", err_zero, 1);

    // R6: backpressure on the result
    m_tready = 1'b0;
    bm[0] = -32'sh0000_C000; bp[0] = 32'sh0000_2000;
    bm[1] = 32'sh0009_0000; bp[1] = 32'sh0000_6000;
    burst(2, 0);
    while (!m_tvalid) @(negedge clk);
    repeat (8) @(negedge clk);
    chk(s_tready == 1'b0, "R5 ready while result waits", s_tready, 0);
    chk(m_tvalid == 1'b1, "R6 valid held", m_tvalid, 1);
    @(posedge clk); #1;
    m_tready = 1'b1;
    drain();
    chk(s_tready == 1'b1, "R5 ready after result taken", s_tready, 1);

    // R4: identical bursts back to back give identical results
    bm[0] = 32'sh0001_0000; bp[0] = 32'sh0000_8000;
    bm[1] = 32'sh000A_0000; bp[1] = 32'sh0000_8000;
    burst(2, 0);
    burst(2, 0);
    drain();

    repeat (4) @(posedge clk);
    chk(eq.size() == 0, "R6 missing result beats", eq.size(), 0);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule